// File: doc/BRIEF.md
# Interrupt Controller Command Interface

This block is the programming front end of an eight-line priority interrupt controller. A host writes bytes to one of two addresses over a simple strobe bus. The block decodes them into an initialization word sequence, end-of-interrupt and priority-rotation commands, and commands that pick the readback register or arm a poll. It owns the interrupt mask, the vector base, the mode flags, the rotation offset and the in-service register. It drives all of these to the neighbouring priority resolver and request capture logic.

The request register and the resolver's current winner come in as inputs. When the host reads while a poll is armed, the block returns the winner and acknowledges it. That acknowledge sets the in-service bit, or rotates priority in auto-EOI mode, and emits a one-cycle acknowledge pulse so the capture logic can drop an edge request. Every read returns its byte on `rd_data` in the cycle after `rd_en`, marked by `rd_valid`.

Top module: `pic_cmd_if`

## Requirements
- R1: After reset, the mask, in-service register, rotation offset, vector base, auto-EOI, nested-mode and special-mask flags are all zero. Readback selects the request register, and the next address-1 write loads the mask.
- R2: A write to address 0 with bit 4 set starts initialization. It records bit 0 as "mode word follows" and bit 1 as "single controller". It clears the mask, in-service register, offset, special mask, rotate-on-auto-EOI, auto-EOI, nested mode, readback select and any armed poll.
- R3: During initialization, address-1 writes never touch the mask. The first one stores the base as value AND 0xF8. A cascade word follows unless single is set. Then the mode word follows if requested, otherwise the sequence returns to idle. In the mode word, bit 4 sets nested mode and bit 1 sets auto-EOI.
- R4: An address-1 write outside initialization loads the mask. The mask changes on no other write.
- R5: An address-0 write with bit 4 clear and bit 3 set is a control word. Bit 2 arms a poll. Bit 1 enables bit 0 as readback select, where 1 selects in-service and 0 selects request. Bit 6 enables bit 5 as the special-mask flag. A disabled field leaves its flag unchanged.
- R6: An address-0 write with bits 4 and 3 clear carries a command in bits 7:5. Code 1 clears the set in-service bit found first when scanning from line `offset` upward with wrap. Code 5 does the same and also sets offset to that line + 1 (mod 8). With no in-service bit set, both do nothing.
- R7: Code 3 clears the in-service bit named by bits 2:0. Code 7 also sets offset to that line + 1 (mod 8).
- R8: Code 6 sets offset to bits 2:0 + 1 (mod 8) and leaves the in-service register alone. Code 2 changes nothing.
- R9: Code 4 sets and code 0 clears rotate-on-auto-EOI. In auto-EOI mode an acknowledge sets no in-service bit. If rotate is also set, the acknowledge sets offset to the acknowledged line + 1.
- R10: A read with a poll armed returns 0x80 OR the winning line and acknowledges it: in-service bit set (outside auto-EOI), `ack_valid` high for one cycle with `ack_line`. With no winner it returns 0x00 and makes no acknowledge. Any read disarms the poll.
- R11: A read without a poll returns, one cycle later with `rd_valid`, the mask at address 1. At address 0 it returns the in-service or request register per the select.
- R12: A poll read and a command write in the same cycle both take effect. The command's in-service clear is applied before the acknowledge's set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 1 | Register address |
| wdata | input | 8 | Write data |
| req_vec | input | 8 | Request register from capture logic |
| win_valid | input | 1 | Resolver has a winner |
| win_line | input | 3 | Winning line from resolver |
| rd_data | output | 8 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| mask_o | output | 8 | Interrupt mask |
| isr_o | output | 8 | In-service register |
| base_o | output | 8 | Vector base |
| prio_offset_o | output | 3 | Rotation offset |
| aeoi_o | output | 1 | Auto-EOI mode |
| sfnm_o | output | 1 | Special fully nested mode |
| special_mask_o | output | 1 | Special mask mode |
| ack_valid | output | 1 | Poll acknowledge pulse |
| ack_line | output | 3 | Acknowledged line |

## Verification
The poll acknowledge and an end-of-interrupt command can land in the same cycle, and both then act on the in-service register and the offset at once. The bench provokes this by raising a read strobe with a poll armed and, in the same cycle, writing a specific EOI. In one case the EOI names the line being acknowledged. In the other it names a different in-service line. It then judges the returned poll byte, the acknowledge pulse and the resulting in-service pattern. The matching-line case must keep the bit set, and the other case must move it.

// File: rtl/pic_cmd_pkg.sv
package pic_cmd_pkg;
  localparam int DW    = 8;
  localparam int NLINE = 8;
  localparam int LW    = $clog2(NLINE);
  localparam logic [DW-1:0] BASE_KEEP = ~(DW'(NLINE - 1));

  typedef enum logic [1:0] {
    STEP_IDLE, STEP_BASE, STEP_CASCADE, STEP_MODE
  } init_step_t;

  typedef enum logic [2:0] {
    OP_ROT_AEOI_CLR = 3'd0,
    OP_NS_EOI       = 3'd1,
    OP_NOP          = 3'd2,
    OP_SP_EOI       = 3'd3,
    OP_ROT_AEOI_SET = 3'd4,
    OP_ROT_NS_EOI   = 3'd5,
    OP_SET_PRIO     = 3'd6,
    OP_ROT_SP_EOI   = 3'd7
  } op_code_t;

  typedef struct packed {
    logic          start;
    logic          need4;
    logic          single;
    logic          ctl;
    logic          poll_set;
    logic          rsel_we;
    logic          rsel_val;
    logic          smm_we;
    logic          smm_val;
    logic          cmd;
    op_code_t      op;
    logic [LW-1:0] line;
    logic          mask_we;
    logic          cfg_we;
  } wdec_t;

  // next line after l, wrapping at NLINE
  function automatic logic [LW-1:0] line_after(input logic [LW-1:0] l);
    return l + LW'(1);
  endfunction

  // first set bit scanning upward from start with wrap; MSB = found
  function automatic logic [LW:0] first_from(input logic [NLINE-1:0] vec,
                                             input logic [LW-1:0] start);
    logic [LW:0]   r;
    logic [LW-1:0] idx;
    r = '0;
    for (int i = NLINE - 1; i >= 0; i--) begin
      idx = start + LW'(i);
      if (vec[idx]) r = {1'b1, idx};
    end
    return r;
  endfunction

  function automatic logic [DW-1:0] poll_byte(input logic hit,
                                              input logic [LW-1:0] line);
    return hit ? (DW'(8'h80) | DW'(line)) : '0;
  endfunction
endpackage

// File: rtl/pic_wr_decode.sv
module pic_wr_decode
  import pic_cmd_pkg::*;
(
  input  logic          wr_en,
  input  logic          addr,
  input  logic [DW-1:0] wdata,
  input  init_step_t    step,
  output wdec_t         dec
);
  logic a0_wr;

  always_comb begin
    a0_wr        = wr_en & ~addr;
    dec          = '0;
    dec.start    = a0_wr & wdata[4];
    dec.need4    = wdata[0];
    dec.single   = wdata[1];
    dec.ctl      = a0_wr & ~wdata[4] & wdata[3];
    dec.poll_set = dec.ctl & wdata[2];
    dec.rsel_we  = dec.ctl & wdata[1];
    dec.rsel_val = wdata[0];
    dec.smm_we   = dec.ctl & wdata[6];
    dec.smm_val  = wdata[5];
    dec.cmd      = a0_wr & ~wdata[4] & ~wdata[3];
    dec.op       = op_code_t'(wdata[7:5]);
    dec.line     = wdata[LW-1:0];
    dec.mask_we  = wr_en & addr & (step == STEP_IDLE);
    dec.cfg_we   = wr_en & addr & (step != STEP_IDLE);
  end
endmodule

// File: rtl/pic_init_seq.sv
module pic_init_seq
  import pic_cmd_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          need4_in,
  input  logic          single_in,
  input  logic          cfg_we,
  input  logic [DW-1:0] cfg_data,
  output init_step_t    step,
  output logic [DW-1:0] base,
  output logic          sfnm,
  output logic          aeoi
);
  logic need4_q, single_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step     <= STEP_IDLE;
      base     <= '0;
      sfnm     <= 1'b0;
      aeoi     <= 1'b0;
      need4_q  <= 1'b0;
      single_q <= 1'b0;
    end else if (start) begin
      step     <= STEP_BASE;
      need4_q  <= need4_in;
      single_q <= single_in;
      sfnm     <= 1'b0;
      aeoi     <= 1'b0;
    end else if (cfg_we) begin
      case (step)
        STEP_BASE: begin
          base <= cfg_data & BASE_KEEP;
          if (!single_q)    step <= STEP_CASCADE;
          else if (need4_q) step <= STEP_MODE;
          else              step <= STEP_IDLE;
        end
        STEP_CASCADE: step <= need4_q ? STEP_MODE : STEP_IDLE;
        STEP_MODE: begin
          sfnm <= cfg_data[4];
          aeoi <= cfg_data[1];
          step <= STEP_IDLE;
        end
        default: step <= STEP_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pic_readback.sv
module pic_readback
  import pic_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic             addr,
  input  logic             poll_pend,
  input  logic             win_valid,
  input  logic [LW-1:0]    win_line,
  input  logic             read_sel,
  input  logic [NLINE-1:0] isr,
  input  logic [NLINE-1:0] req,
  input  logic [NLINE-1:0] mask,
  output logic [DW-1:0]    rd_data,
  output logic             rd_valid
);
  logic [DW-1:0] sel_byte;

  always_comb begin
    if (poll_pend)     sel_byte = poll_byte(win_valid, win_line);
    else if (addr)     sel_byte = DW'(mask);
    else if (read_sel) sel_byte = DW'(isr);
    else               sel_byte = DW'(req);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= sel_byte;
    end
  end
endmodule

// File: rtl/pic_cmd_if.sv
module pic_cmd_if
  import pic_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic             addr,
  input  logic [DW-1:0]    wdata,
  input  logic [NLINE-1:0] req_vec,
  input  logic             win_valid,
  input  logic [LW-1:0]    win_line,
  output logic [DW-1:0]    rd_data,
  output logic             rd_valid,
  output logic [NLINE-1:0] mask_o,
  output logic [NLINE-1:0] isr_o,
  output logic [DW-1:0]    base_o,
  output logic [LW-1:0]    prio_offset_o,
  output logic             aeoi_o,
  output logic             sfnm_o,
  output logic             special_mask_o,
  output logic             ack_valid,
  output logic [LW-1:0]    ack_line
);
  wdec_t            dec;
  init_step_t       step;
  logic [NLINE-1:0] mask_q, isr_q;
  logic [LW-1:0]    off_q;
  logic             rot_aeoi_q, smm_q, rsel_q, poll_q;
  logic             ack_q;
  logic [LW-1:0]    ack_line_q;

  // named internal events
  logic             poll_ack;
  logic [LW:0]      ns_pick;
  logic             eoi_ns, eoi_sp, eoi_rot, ack_rot, prio_set;
  logic [LW-1:0]    eoi_line;
  logic [NLINE-1:0] eoi_clr, ack_set, isr_nxt;
  logic [LW-1:0]    off_nxt;

  pic_wr_decode u_dec (
    .wr_en (wr_en),
    .addr  (addr),
    .wdata (wdata),
    .step  (step),
    .dec   (dec)
  );

  pic_init_seq u_init (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (dec.start),
    .need4_in  (dec.need4),
    .single_in (dec.single),
    .cfg_we    (dec.cfg_we),
    .cfg_data  (wdata),
    .step      (step),
    .base      (base_o),
    .sfnm      (sfnm_o),
    .aeoi      (aeoi_o)
  );

  pic_readback u_rb (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .addr      (addr),
    .poll_pend (poll_q),
    .win_valid (win_valid),
    .win_line  (win_line),
    .read_sel  (rsel_q),
    .isr       (isr_q),
    .req       (req_vec),
    .mask      (mask_q),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid)
  );

  always_comb begin
    poll_ack = rd_en & poll_q & win_valid;
    ns_pick  = first_from(isr_q, off_q);
    eoi_ns   = dec.cmd & ((dec.op == OP_NS_EOI) | (dec.op == OP_ROT_NS_EOI)) & ns_pick[LW];
    eoi_sp   = dec.cmd & ((dec.op == OP_SP_EOI) | (dec.op == OP_ROT_SP_EOI));
    eoi_line = eoi_sp ? dec.line : ns_pick[LW-1:0];
    eoi_clr  = (eoi_ns | eoi_sp) ? (NLINE'(1) << eoi_line) : '0;
    eoi_rot  = (eoi_ns & (dec.op == OP_ROT_NS_EOI)) | (eoi_sp & (dec.op == OP_ROT_SP_EOI));
    prio_set = dec.cmd & (dec.op == OP_SET_PRIO);
    ack_set  = (poll_ack & ~aeoi_o) ? (NLINE'(1) << win_line) : '0;
    ack_rot  = poll_ack & aeoi_o & rot_aeoi_q;
    // clear from the command first, then the acknowledge's set
    isr_nxt  = (isr_q & ~eoi_clr) | ack_set;
    off_nxt  = off_q;
    if (prio_set) off_nxt = line_after(dec.line);
    if (eoi_rot)  off_nxt = line_after(eoi_line);
    if (ack_rot)  off_nxt = line_after(win_line);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q     <= '0;
      isr_q      <= '0;
      off_q      <= '0;
      rot_aeoi_q <= 1'b0;
      smm_q      <= 1'b0;
      rsel_q     <= 1'b0;
      poll_q     <= 1'b0;
    end else if (dec.start) begin
      mask_q     <= '0;
      isr_q      <= '0;
      off_q      <= '0;
      rot_aeoi_q <= 1'b0;
      smm_q      <= 1'b0;
      rsel_q     <= 1'b0;
      poll_q     <= 1'b0;
    end else begin
      isr_q <= isr_nxt;
      off_q <= off_nxt;
      if (dec.mask_we) mask_q <= wdata[NLINE-1:0];
      if (dec.cmd && (dec.op == OP_ROT_AEOI_CLR || dec.op == OP_ROT_AEOI_SET))
        rot_aeoi_q <= dec.op[2];
      if (dec.rsel_we) rsel_q <= dec.rsel_val;
      if (dec.smm_we)  smm_q  <= dec.smm_val;
      if (dec.poll_set)  poll_q <= 1'b1;
      else if (rd_en)    poll_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q      <= 1'b0;
      ack_line_q <= '0;
    end else begin
      ack_q <= poll_ack;
      if (poll_ack) ack_line_q <= win_line;
    end
  end

  assign mask_o         = mask_q;
  assign isr_o          = isr_q;
  assign prio_offset_o  = off_q;
  assign special_mask_o = smm_q;
  assign ack_valid      = ack_q;
  assign ack_line       = ack_line_q;
endmodule

// File: rtl/pic_cmd_if_chk.sv
module pic_cmd_if_chk
  import pic_cmd_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             rd_en,
  input logic [DW-1:0]    wdata,
  input logic [DW-1:0]    rd_data,
  input logic             rd_valid,
  input logic [NLINE-1:0] mask_o,
  input logic [NLINE-1:0] isr_o,
  input logic             aeoi_o,
  input logic             ack_valid,
  input logic [LW-1:0]    ack_line
);
  a_r11_valid_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  a_r11_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);

  a_r10_ack_with_poll_byte: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> (rd_valid && rd_data[7] && (rd_data[LW-1:0] == ack_line)));

  a_r4_mask_held_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mask_o));

  a_r6_eoi_clears_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_en && !wdata[4]) |=> ($countones($past(isr_o) & ~isr_o) <= 1));

  a_r9_aeoi_sets_no_isr: assert property (@(posedge clk) disable iff (!rst_n)
    (aeoi_o && !wr_en) |=> ((isr_o & ~$past(isr_o)) == '0));
endmodule

bind pic_cmd_if pic_cmd_if_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .wdata     (wdata),
  .rd_data   (rd_data),
  .rd_valid  (rd_valid),
  .mask_o    (mask_o),
  .isr_o     (isr_o),
  .aeoi_o    (aeoi_o),
  .ack_valid (ack_valid),
  .ack_line  (ack_line)
);

// File: tb/sim_pic_cmd_if.sv
module sim_pic_cmd_if;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
  logic [7:0] wdata = '0, req_vec = '0;
  logic       win_valid = 1'b0;
  logic [2:0] win_line = '0;
  logic [7:0] rd_data, mask_o, isr_o, base_o;
  logic       rd_valid, aeoi_o, sfnm_o, special_mask_o, ack_valid;
  logic [2:0] prio_offset_o, ack_line;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  pic_cmd_if u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .req_vec(req_vec), .win_valid(win_valid), .win_line(win_line),
    .rd_data(rd_data), .rd_valid(rd_valid), .mask_o(mask_o), .isr_o(isr_o),
    .base_o(base_o), .prio_offset_o(prio_offset_o), .aeoi_o(aeoi_o),
    .sfnm_o(sfnm_o), .special_mask_o(special_mask_o),
    .ack_valid(ack_valid), .ack_line(ack_line)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read bytes as the design returns them
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R11 unexpected read actual=%h expected=none", rd_data);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rd_data !== e) begin
          errors++;
          $display("FAIL %s read actual=%h expected=%h", t, rd_data, e);
        end
      end
    end
  end

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // read (optionally with a same-cycle write); checks ack pulse afterwards
  task automatic rdwr(input logic a, input logic [7:0] exp, input string tag,
                      input logic do_wr, input logic [7:0] wd,
                      input logic exp_ack, input logic [2:0] exp_ln);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    if (do_wr) begin wr_en = 1'b1; wdata = wd; end
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    chk({tag, " ack"}, {7'd0, ack_valid}, {7'd0, exp_ack});
    if (exp_ack) chk({tag, " ack_line"}, {5'd0, ack_line}, {5'd0, exp_ln});
  endtask

  task automatic poll_hit(input logic [2:0] ln, input string tag);
    wr(1'b0, 8'h0C);
    win_valid = 1'b1; win_line = ln;
    rdwr(1'b0, 8'h80 | {5'd0, ln}, tag, 1'b0, 8'h00, 1'b1, ln);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 mask", mask_o, 8'h00);
    chk("R1 isr", isr_o, 8'h00);
    chk("R1 offset", {5'd0, prio_offset_o}, 8'h00);
    chk("R1 flags", {5'd0, aeoi_o, sfnm_o, special_mask_o}, 8'h00);
    rdwr(1'b1, 8'h00, "R1 mask read", 1'b0, 8'h00, 1'b0, 3'd0);

    // R2/R3 full sequence: cascade + mode word
    wr(1'b0, 8'h11);
    wr(1'b1, 8'h47);
    chk("R3 base", base_o, 8'h40);
    chk("R3 mask untouched", mask_o, 8'h00);
    wr(1'b1, 8'h00);
    wr(1'b1, 8'h00);
    chk("R3 mode flags", {6'd0, aeoi_o, sfnm_o}, 8'h00);
    wr(1'b1, 8'hA5);
    chk("R4 mask load", mask_o, 8'hA5);
    rdwr(1'b1, 8'hA5, "R11 mask read", 1'b0, 8'h00, 1'b0, 3'd0);

    // R10 poll with winner
    req_vec = 8'h5A;
    poll_hit(3'd3, "R10 poll line3");
    chk("R10 isr set", isr_o, 8'h08);
    win_valid = 1'b0;
    rdwr(1'b0, 8'h5A, "R10 poll cleared / R11 request read", 1'b0, 8'h00, 1'b0, 3'd0);
    wr(1'b0, 8'h0B);
    rdwr(1'b0, 8'h08, "R5 R11 isr select", 1'b0, 8'h00, 1'b0, 3'd0);
    wr(1'b0, 8'h0C);
    rdwr(1'b0, 8'h00, "R10 poll no winner", 1'b0, 8'h00, 1'b0, 3'd0);
    chk("R10 isr kept", isr_o, 8'h08);

    // R6/R8 EOI and rotation
    poll_hit(3'd1, "R10 poll line1");
    poll_hit(3'd6, "R10 poll line6");
    win_valid = 1'b0;
    chk("R10 isr build", isr_o, 8'h4A);
    wr(1'b0, 8'h20);
    chk("R6 ns eoi", isr_o, 8'h48);
    wr(1'b0, 8'hC4);
    chk("R8 set prio offset", {5'd0, prio_offset_o}, 8'h05);
    chk("R8 set prio isr", isr_o, 8'h48);
    wr(1'b0, 8'hA0);
    chk("R6 rot ns eoi isr", isr_o, 8'h08);
    chk("R6 rot ns eoi offset", {5'd0, prio_offset_o}, 8'h07);
    wr(1'b0, 8'h47);
    chk("R8 nop isr", isr_o, 8'h08);
    chk("R8 nop offset", {5'd0, prio_offset_o}, 8'h07);
    wr(1'b0, 8'h63);
    chk("R7 specific eoi", isr_o, 8'h00);
    poll_hit(3'd2, "R10 poll line2");
    win_valid = 1'b0;
    wr(1'b0, 8'hE2);
    chk("R7 rot specific isr", isr_o, 8'h00);
    chk("R7 rot specific offset", {5'd0, prio_offset_o}, 8'h03);
    wr(1'b0, 8'hA0);
    chk("R6 empty isr offset", {5'd0, prio_offset_o}, 8'h03);

    // R5 special mask
    wr(1'b0, 8'h68);
    chk("R5 smm set", {7'd0, special_mask_o}, 8'h01);
    wr(1'b0, 8'h28);
    chk("R5 smm disabled field", {7'd0, special_mask_o}, 8'h01);
    wr(1'b0, 8'h48);
    chk("R5 smm clear", {7'd0, special_mask_o}, 8'h00);

    // R2 re-init: single + mode word
    wr(1'b0, 8'h68);
    wr(1'b0, 8'h13);
    chk("R2 mask cleared", mask_o, 8'h00);
    chk("R2 offset cleared", {5'd0, prio_offset_o}, 8'h00);
    chk("R2 smm cleared", {7'd0, special_mask_o}, 8'h00);
    wr(1'b1, 8'h27);
    chk("R3 base masked", base_o, 8'h20);
    chk("R3 mask untouched init", mask_o, 8'h00);
    wr(1'b1, 8'h12);
    chk("R3 aeoi/sfnm", {6'd0, aeoi_o, sfnm_o}, 8'h03);
    wr(1'b1, 8'h0F);
    chk("R4 mask after init", mask_o, 8'h0F);
    rdwr(1'b0, 8'h5A, "R2 read select reset", 1'b0, 8'h00, 1'b0, 3'd0);

    // R9 rotate on auto-EOI
    wr(1'b0, 8'h80);
    poll_hit(3'd5, "R9 poll aeoi line5");
    chk("R9 no isr", isr_o, 8'h00);
    chk("R9 rotate offset", {5'd0, prio_offset_o}, 8'h06);
    wr(1'b0, 8'h00);
    poll_hit(3'd2, "R9 poll aeoi line2");
    chk("R9 no rotate offset", {5'd0, prio_offset_o}, 8'h06);
    chk("R9 no isr again", isr_o, 8'h00);

    // R12 same-cycle poll acknowledge and specific EOI
    wr(1'b0, 8'h12);
    wr(1'b1, 8'h08);
    chk("R3 single no mode word", {6'd0, aeoi_o, sfnm_o}, 8'h00);
    chk("R3 base 08", base_o, 8'h08);
    poll_hit(3'd4, "R10 poll line4");
    chk("R10 isr line4", isr_o, 8'h10);
    wr(1'b0, 8'h0C);
    win_line = 3'd4;
    rdwr(1'b0, 8'h84, "R12 same line", 1'b1, 8'h64, 1'b1, 3'd4);
    chk("R12 clear then set", isr_o, 8'h10);
    wr(1'b0, 8'h0C);
    win_line = 3'd1;
    rdwr(1'b0, 8'h81, "R12 other line", 1'b1, 8'h64, 1'b1, 3'd1);
    chk("R12 moved", isr_o, 8'h02);

    repeat (3) @(negedge clk);
    chk("R11 all reads returned", 8'(exp_q.size()), 8'h00);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule